// File: doc/BRIEF.md
# Reorder Buffer Commit Controller

This block is the in-order retirement stage of an out-of-order pipeline, built around a circular reorder buffer of `DEPTH` entries. Each cycle it takes a group of up to `REN_W` dispatched instructions from rename and appends the live ones in program order. It gives each appended entry the next sequence number from a counter that only ever counts up. The execute stage reports finished work by buffer tag. The controller then retires ready entries from the head, at most `CMT_W` per cycle, and sends the last retired sequence number back upstream.

An instruction marked non-speculative is placed in the buffer already eligible, but it has not yet executed. When it reaches the head, the controller asks the execute stage to run it and waits. A squash request from execute starts a walk that removes one younger entry per cycle from the tail. While the walk runs, nothing is inserted and nothing retires.

The controller reports its free-entry count upstream every cycle. Faults are carried only as a per-entry flag, and retiring a faulted entry raises an error pulse.

Top module: `rob_commit_ctrl`

## Requirements
- R1: At most `CMT_W` head entries leave the buffer per cycle. `bk_retired_o` gives the number of real commits of the previous cycle. When it is non-zero, `bk_seq_o` holds the sequence number of the youngest entry committed.
- R2: Retirement is in order and stops at the first head entry that is not ready. Ready entries behind it wait.
- R3: An entry killed by a completion report with `cmp_kill_i` set leaves the buffer as soon as it is at the head. It is not counted in `bk_retired_o` and does not update `bk_seq_o`.
- R4: A non-speculative entry at the head that has not executed is not retired. One cycle later `bk_nreq_o` pulses with its sequence number on `bk_nreq_seq_o`. The entry stays blocked until a completion report for its tag arrives, and retirement stops for that cycle.
- R5: A squash request accepted while running produces, one cycle later, `bk_squash_o` and `bk_robsq_o` both high, and `bk_seq_o` equal to the request's sequence number. The mispredict, taken and next-PC fields are passed through.
- R6: After a squash, one entry per cycle is removed from the tail while its sequence number is younger than the squash point. Each removal is reported with `bk_robsq_o` high and the removed sequence number. The cycle that finds no younger entry returns the block to running, and `bk_robsq_o` is low for that cycle.
- R7: Rename slots below `ren_cnt_i` are appended in slot order. Slots with `ren_kill_i` set are skipped. Appended entries take consecutive tags from `alloc_tag_o` and consecutive sequence numbers from `alloc_seq_o`.
- R8: A completion report marks its entry ready after that cycle's retirement decision. An entry reported in cycle N retires no earlier than cycle N+1. Reports are also accepted during a squash walk.
- R9: `bk_free_o` equals `DEPTH` minus the current occupancy. It never exceeds `DEPTH` and never underflows.
- R10: `ren_stall_o` is high while walking, or when the free count is less than `ren_cnt_i`. While it is high, nothing is appended and `alloc_seq_o` does not move.
- R11: Committing an entry whose rename fault flag was set pulses `bk_fault_o` for one cycle.
- R12: After reset the buffer is empty, `bk_free_o` equals `DEPTH`, both allocation outputs are zero and every pulse output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ren_cnt_i | input | RC_W | Number of valid rename slots this cycle |
| ren_kill_i | input | REN_W | Per-slot flag: already squashed, do not append |
| ren_nspec_i | input | REN_W | Per-slot non-speculative flag |
| ren_fault_i | input | REN_W | Per-slot fault flag |
| ren_stall_o | output | 1 | Backpressure: the group is not appended |
| alloc_tag_o | output | IDX_W | Tag that the first appended entry will receive |
| alloc_seq_o | output | SEQ_W | Sequence number that the first appended entry will receive |
| cmp_vld_i | input | CMP_W | Completion report valid per lane |
| cmp_tag_i | input | CMP_W*IDX_W | Completion tags, lane j at bits [j*IDX_W +: IDX_W] |
| cmp_kill_i | input | CMP_W | Report marks the entry killed instead of executed |
| sq_req_i | input | 1 | Squash request from execute |
| sq_seq_i | input | SEQ_W | Sequence number of the squashing instruction |
| sq_mispred_i | input | 1 | Mispredict flag to pass through |
| sq_taken_i | input | 1 | Taken flag to pass through |
| sq_npc_i | input | PC_W | Redirect PC to pass through |
| bk_free_o | output | PTR_W | Free entries |
| bk_retired_o | output | CC_W | Entries committed in the previous cycle |
| bk_seq_vld_o | output | 1 | `bk_seq_o` was updated in the previous cycle |
| bk_seq_o | output | SEQ_W | Last committed, squash-point or removed sequence number |
| bk_squash_o | output | 1 | Squash broadcast pulse |
| bk_robsq_o | output | 1 | Buffer is squashing |
| bk_mispred_o | output | 1 | Passed-through mispredict flag |
| bk_taken_o | output | 1 | Passed-through taken flag |
| bk_npc_o | output | PC_W | Passed-through redirect PC |
| bk_nreq_o | output | 1 | Request to execute the non-speculative head |
| bk_nreq_seq_o | output | SEQ_W | Sequence number of that head |
| bk_fault_o | output | 1 | A faulted entry was committed |

## Verification
The assertions assume that execute sends completion reports only for tags that are live in the buffer, and never a second report for a tag. They also assume that a squash request arrives only while the block is running. The stimulus respects this: the bench keeps its own model of which tags are occupied, reports each tag exactly once, and issues a single squash whose sequence number lies inside the buffer. Sequence numbers stay well within half the counter range, so age comparisons are never ambiguous.

// File: rtl/rcc_pkg.sv
package rcc_pkg;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_WALK = 1'b1
    } rcc_state_e;

endpackage

// File: rtl/rcc_insert_pack.sv
module rcc_insert_pack #(
    parameter int REN_W = 2,
    parameter int RC_W  = 2
) (
    input  logic [RC_W-1:0]       ren_cnt_i,
    input  logic [REN_W-1:0]      ren_kill_i,
    input  logic                  en_i,
    output logic [REN_W-1:0]      slot_en_o,
    output logic [REN_W*RC_W-1:0] slot_off_o,
    output logic [RC_W-1:0]       total_o
);

    logic [RC_W-1:0] acc;

    always_comb begin
        acc        = '0;
        slot_en_o  = '0;
        slot_off_o = '0;
        for (int i = 0; i < REN_W; i++) begin
            slot_off_o[i*RC_W +: RC_W] = acc;
            if (en_i && (int'(ren_cnt_i) > i) && !ren_kill_i[i]) begin
                slot_en_o[i] = 1'b1;
                acc          = acc + RC_W'(1);
            end
        end
        total_o = acc;
    end

endmodule

// File: rtl/rcc_mark_decode.sv
module rcc_mark_decode #(
    parameter int DEPTH = 8,
    parameter int CMP_W = 2,
    parameter int IDX_W = 3
) (
    input  logic [CMP_W-1:0]       cmp_vld_i,
    input  logic [CMP_W*IDX_W-1:0] cmp_tag_i,
    input  logic [CMP_W-1:0]       cmp_kill_i,
    output logic [DEPTH-1:0]       mark_o,
    output logic [DEPTH-1:0]       kmark_o
);

    logic [CMP_W-1:0][DEPTH-1:0] lane_hot;

    for (genvar j = 0; j < CMP_W; j++) begin : g_lane
        always_comb begin
            lane_hot[j] = '0;
            if (cmp_vld_i[j]) begin
                lane_hot[j][cmp_tag_i[j*IDX_W +: IDX_W]] = 1'b1;
            end
        end
    end

    always_comb begin
        mark_o  = '0;
        kmark_o = '0;
        for (int j = 0; j < CMP_W; j++) begin
            mark_o = mark_o | lane_hot[j];
            if (cmp_kill_i[j]) begin
                kmark_o = kmark_o | lane_hot[j];
            end
        end
    end

endmodule

// File: rtl/rcc_retire_lanes.sv
module rcc_retire_lanes #(
    parameter int CMT_W = 2,
    parameter int CC_W  = 2,
    parameter int PTR_W = 4
) (
    input  logic             en_i,
    input  logic [PTR_W-1:0] count_i,
    input  logic [CMT_W-1:0] lane_rdy_i,
    input  logic [CMT_W-1:0] lane_exe_i,
    input  logic [CMT_W-1:0] lane_kil_i,
    output logic [CMT_W-1:0] lane_leave_o,
    output logic [CMT_W-1:0] lane_cmt_o,
    output logic [CMT_W-1:0] lane_nreq_o,
    output logic [CC_W-1:0]  leave_cnt_o,
    output logic [CC_W-1:0]  cmt_cnt_o
);

    logic go;
    logic bad;

    always_comb begin
        go           = en_i;
        lane_leave_o = '0;
        lane_cmt_o   = '0;
        lane_nreq_o  = '0;
        leave_cnt_o  = '0;
        cmt_cnt_o    = '0;
        for (int k = 0; k < CMT_W; k++) begin
            if (go && (int'(count_i) > k) && lane_rdy_i[k]) begin
                if (lane_kil_i[k]) begin
                    lane_leave_o[k] = 1'b1;
                    leave_cnt_o     = leave_cnt_o + CC_W'(1);
                end else if (!lane_exe_i[k]) begin
                    lane_nreq_o[k] = 1'b1;
                    go             = 1'b0;
                end else begin
                    lane_leave_o[k] = 1'b1;
                    lane_cmt_o[k]   = 1'b1;
                    leave_cnt_o     = leave_cnt_o + CC_W'(1);
                    cmt_cnt_o       = cmt_cnt_o + CC_W'(1);
                end
            end else begin
                go = 1'b0;
            end
        end
    end

    always_comb begin
        bad = 1'b0;
        for (int k = 0; k < CMT_W; k++) begin
            for (int j = k + 1; j < CMT_W; j++) begin
                if ((lane_nreq_o[k] || !lane_leave_o[k]) && lane_leave_o[j]) begin
                    bad = 1'b1;
                end
            end
        end
        // R2 R4
        nreq_stop_chk: assert (!bad);
    end

endmodule

// File: rtl/rob_commit_ctrl.sv
module rob_commit_ctrl #(
    parameter int DEPTH = 8,
    parameter int REN_W = 2,
    parameter int CMT_W = 2,
    parameter int CMP_W = 2,
    parameter int SEQ_W = 8,
    parameter int PC_W  = 16,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1,
    localparam int RC_W  = $clog2(REN_W + 1),
    localparam int CC_W  = $clog2(CMT_W + 1)
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [RC_W-1:0]        ren_cnt_i,
    input  logic [REN_W-1:0]       ren_kill_i,
    input  logic [REN_W-1:0]       ren_nspec_i,
    input  logic [REN_W-1:0]       ren_fault_i,
    output logic                   ren_stall_o,
    output logic [IDX_W-1:0]       alloc_tag_o,
    output logic [SEQ_W-1:0]       alloc_seq_o,
    input  logic [CMP_W-1:0]       cmp_vld_i,
    input  logic [CMP_W*IDX_W-1:0] cmp_tag_i,
    input  logic [CMP_W-1:0]       cmp_kill_i,
    input  logic                   sq_req_i,
    input  logic [SEQ_W-1:0]       sq_seq_i,
    input  logic                   sq_mispred_i,
    input  logic                   sq_taken_i,
    input  logic [PC_W-1:0]        sq_npc_i,
    output logic [PTR_W-1:0]       bk_free_o,
    output logic [CC_W-1:0]        bk_retired_o,
    output logic                   bk_seq_vld_o,
    output logic [SEQ_W-1:0]       bk_seq_o,
    output logic                   bk_squash_o,
    output logic                   bk_robsq_o,
    output logic                   bk_mispred_o,
    output logic                   bk_taken_o,
    output logic [PC_W-1:0]        bk_npc_o,
    output logic                   bk_nreq_o,
    output logic [SEQ_W-1:0]       bk_nreq_seq_o,
    output logic                   bk_fault_o
);

    localparam logic [PTR_W-1:0] DEPTH_L = PTR_W'(DEPTH);

    typedef struct packed {
        rcc_pkg::rcc_state_e          st;
        logic [PTR_W-1:0]             head;
        logic [PTR_W-1:0]             tail;
        logic [SEQ_W-1:0]             seq_ctr;
        logic [SEQ_W-1:0]             sq_seq;
        logic [DEPTH-1:0]             rdy;
        logic [DEPTH-1:0]             exe;
        logic [DEPTH-1:0]             kil;
        logic [DEPTH-1:0]             flt;
        logic [DEPTH-1:0][SEQ_W-1:0]  eseq;
        logic [CC_W-1:0]              retired;
        logic                         seq_vld;
        logic [SEQ_W-1:0]             seq_out;
        logic                         squash;
        logic                         robsq;
        logic                         mispred;
        logic                         taken;
        logic [PC_W-1:0]              npc;
        logic                         nreq;
        logic [SEQ_W-1:0]             nreq_seq;
        logic                         fault;
    } state_t;

    state_t st_q, st_d;

    logic [PTR_W-1:0]       count;
    logic [PTR_W-1:0]       free_cnt;
    logic                   do_run;
    logic                   stall;
    logic [IDX_W-1:0]       lidx [CMT_W];
    logic [CMT_W-1:0]       lane_rdy, lane_exe, lane_kil;
    logic [CMT_W-1:0]       lane_leave, lane_cmt, lane_nreq;
    logic [CC_W-1:0]        leave_cnt, cmt_cnt;
    logic [REN_W-1:0]       slot_en;
    logic [REN_W*RC_W-1:0]  slot_off;
    logic [RC_W-1:0]        ins_total;
    logic [DEPTH-1:0]       mark, kmark;
    logic [PTR_W-1:0]       tail_m1;
    logic [SEQ_W-1:0]       age_diff;
    logic [PTR_W-1:0]       lane_ptr [CMT_W];
    logic [PTR_W-1:0]       wptr;

    assign count    = st_q.tail - st_q.head;
    assign free_cnt = DEPTH_L - count;
    assign do_run   = (st_q.st == rcc_pkg::ST_RUN) && !sq_req_i;
    assign stall    = (st_q.st == rcc_pkg::ST_WALK) || (free_cnt < PTR_W'(ren_cnt_i));
    assign tail_m1  = st_q.tail - PTR_W'(1);
    assign age_diff = st_q.eseq[tail_m1[IDX_W-1:0]] - st_q.sq_seq;

    always_comb begin
        for (int k = 0; k < CMT_W; k++) begin
            lane_ptr[k] = st_q.head + PTR_W'(k);
            lidx[k]     = lane_ptr[k][IDX_W-1:0];
            lane_rdy[k] = st_q.rdy[lidx[k]];
            lane_exe[k] = st_q.exe[lidx[k]];
            lane_kil[k] = st_q.kil[lidx[k]];
        end
    end

    rcc_retire_lanes #(.CMT_W(CMT_W), .CC_W(CC_W), .PTR_W(PTR_W)) u_lanes (
        .en_i         (do_run),
        .count_i      (count),
        .lane_rdy_i   (lane_rdy),
        .lane_exe_i   (lane_exe),
        .lane_kil_i   (lane_kil),
        .lane_leave_o (lane_leave),
        .lane_cmt_o   (lane_cmt),
        .lane_nreq_o  (lane_nreq),
        .leave_cnt_o  (leave_cnt),
        .cmt_cnt_o    (cmt_cnt)
    );

    rcc_insert_pack #(.REN_W(REN_W), .RC_W(RC_W)) u_ins (
        .ren_cnt_i  (ren_cnt_i),
        .ren_kill_i (ren_kill_i),
        .en_i       (do_run && !stall),
        .slot_en_o  (slot_en),
        .slot_off_o (slot_off),
        .total_o    (ins_total)
    );

    rcc_mark_decode #(.DEPTH(DEPTH), .CMP_W(CMP_W), .IDX_W(IDX_W)) u_mark (
        .cmp_vld_i  (cmp_vld_i),
        .cmp_tag_i  (cmp_tag_i),
        .cmp_kill_i (cmp_kill_i),
        .mark_o     (mark),
        .kmark_o    (kmark)
    );

    always_comb begin
        st_d         = st_q;
        st_d.retired = '0;
        st_d.seq_vld = 1'b0;
        st_d.squash  = 1'b0;
        st_d.robsq   = 1'b0;
        st_d.nreq    = 1'b0;
        st_d.fault   = 1'b0;
        wptr         = '0;

        if (st_q.st == rcc_pkg::ST_RUN) begin
            if (sq_req_i) begin
                st_d.st      = rcc_pkg::ST_WALK;
                st_d.sq_seq  = sq_seq_i;
                st_d.squash  = 1'b1;
                st_d.robsq   = 1'b1;
                st_d.seq_vld = 1'b1;
                st_d.seq_out = sq_seq_i;
                st_d.mispred = sq_mispred_i;
                st_d.taken   = sq_taken_i;
                st_d.npc     = sq_npc_i;
            end else begin
                for (int k = 0; k < CMT_W; k++) begin
                    if (lane_cmt[k]) begin
                        st_d.seq_vld = 1'b1;
                        st_d.seq_out = st_q.eseq[lidx[k]];
                        if (st_q.flt[lidx[k]]) begin
                            st_d.fault = 1'b1;
                        end
                    end
                    if (lane_nreq[k]) begin
                        st_d.rdy[lidx[k]] = 1'b0;
                        st_d.nreq         = 1'b1;
                        st_d.nreq_seq     = st_q.eseq[lidx[k]];
                    end
                end
                st_d.head    = st_q.head + PTR_W'(leave_cnt);
                st_d.retired = cmt_cnt;
            end
        end else begin
            if ((count != '0) && !age_diff[SEQ_W-1] && (age_diff != '0)) begin
                st_d.tail    = tail_m1;
                st_d.robsq   = 1'b1;
                st_d.seq_vld = 1'b1;
                st_d.seq_out = st_q.eseq[tail_m1[IDX_W-1:0]];
            end else begin
                st_d.st = rcc_pkg::ST_RUN;
            end
        end

        // completion marks land after the retirement decision above
        st_d.rdy = st_d.rdy | mark;
        st_d.exe = st_d.exe | (mark & ~kmark);
        st_d.kil = st_d.kil | kmark;

        // new entries overwrite any stale state in their slots
        for (int i = 0; i < REN_W; i++) begin
            if (slot_en[i]) begin
                wptr = st_q.tail + PTR_W'(slot_off[i*RC_W +: RC_W]);
                st_d.rdy[wptr[IDX_W-1:0]]  = ren_nspec_i[i];
                st_d.exe[wptr[IDX_W-1:0]]  = 1'b0;
                st_d.kil[wptr[IDX_W-1:0]]  = 1'b0;
                st_d.flt[wptr[IDX_W-1:0]]  = ren_fault_i[i];
                st_d.eseq[wptr[IDX_W-1:0]] = st_q.seq_ctr + SEQ_W'(slot_off[i*RC_W +: RC_W]);
            end
        end
        st_d.tail    = st_d.tail + PTR_W'(ins_total);
        st_d.seq_ctr = st_q.seq_ctr + SEQ_W'(ins_total);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ren_stall_o   = stall;
    assign alloc_tag_o   = st_q.tail[IDX_W-1:0];
    assign alloc_seq_o   = st_q.seq_ctr;
    assign bk_free_o     = free_cnt;
    assign bk_retired_o  = st_q.retired;
    assign bk_seq_vld_o  = st_q.seq_vld;
    assign bk_seq_o      = st_q.seq_out;
    assign bk_squash_o   = st_q.squash;
    assign bk_robsq_o    = st_q.robsq;
    assign bk_mispred_o  = st_q.mispred;
    assign bk_taken_o    = st_q.taken;
    assign bk_npc_o      = st_q.npc;
    assign bk_nreq_o     = st_q.nreq;
    assign bk_nreq_seq_o = st_q.nreq_seq;
    assign bk_fault_o    = st_q.fault;

    // R9
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.tail - st_q.head) <= DEPTH_L);

    // R1
    commit_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int'(bk_retired_o) <= CMT_W);

    // R5
    squash_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.st == rcc_pkg::ST_RUN && sq_req_i) |=>
            (bk_squash_o && bk_robsq_o && bk_seq_o == $past(sq_seq_i)));

    // R6
    walk_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.st == rcc_pkg::ST_WALK) |=>
            (bk_retired_o == '0 && alloc_seq_o == $past(alloc_seq_o)));

    // R10
    stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ren_stall_o |=> (alloc_seq_o == $past(alloc_seq_o)));

endmodule

// File: tb/rob_commit_ctrl_test.sv
module rob_commit_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  ren_cnt = '0;
    logic [1:0]  ren_kill = '0, ren_nspec = '0, ren_fault = '0;
    logic        ren_stall;
    logic [2:0]  alloc_tag;
    logic [7:0]  alloc_seq;
    logic [1:0]  cmp_vld = '0;
    logic [5:0]  cmp_tag = '0;
    logic [1:0]  cmp_kill = '0;
    logic        sq_req = 1'b0;
    logic [7:0]  sq_seq = '0;
    logic        sq_mispred = 1'b0, sq_taken = 1'b0;
    logic [15:0] sq_npc = '0;
    logic [3:0]  bk_free;
    logic [1:0]  bk_retired;
    logic        bk_seq_vld;
    logic [7:0]  bk_seq;
    logic        bk_squash, bk_robsq, bk_mispred, bk_taken;
    logic [15:0] bk_npc;
    logic        bk_nreq;
    logic [7:0]  bk_nreq_seq;
    logic        bk_fault;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rob_commit_ctrl uut (
        .clk_i(clk), .rst_ni(rst_n),
        .ren_cnt_i(ren_cnt), .ren_kill_i(ren_kill), .ren_nspec_i(ren_nspec),
        .ren_fault_i(ren_fault), .ren_stall_o(ren_stall),
        .alloc_tag_o(alloc_tag), .alloc_seq_o(alloc_seq),
        .cmp_vld_i(cmp_vld), .cmp_tag_i(cmp_tag), .cmp_kill_i(cmp_kill),
        .sq_req_i(sq_req), .sq_seq_i(sq_seq), .sq_mispred_i(sq_mispred),
        .sq_taken_i(sq_taken), .sq_npc_i(sq_npc),
        .bk_free_o(bk_free), .bk_retired_o(bk_retired), .bk_seq_vld_o(bk_seq_vld),
        .bk_seq_o(bk_seq), .bk_squash_o(bk_squash), .bk_robsq_o(bk_robsq),
        .bk_mispred_o(bk_mispred), .bk_taken_o(bk_taken), .bk_npc_o(bk_npc),
        .bk_nreq_o(bk_nreq), .bk_nreq_seq_o(bk_nreq_seq), .bk_fault_o(bk_fault)
    );

    typedef struct packed {
        logic [1:0] cnt;
        logic [1:0] nsp;
        logic       c0v;
        logic [2:0] c0t;
        logic       c1v;
        logic [2:0] c1t;
        logic [1:0] xret;
        logic [3:0] xfree;
        logic [7:0] xseq;
        logic       xnreq;
    } vec_t;

    // cnt nsp c0v c0t c1v c1t | ret free seq nreq
    localparam vec_t TBL [18] = '{
        '{2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd2, 2'd0, 1'b1, 3'd0, 1'b1, 3'd1, 2'd0, 4'd4, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b1, 3'd2, 1'b1, 3'd3, 2'd2, 4'd6, 8'd1,  1'b0},
        '{2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd2, 4'd6, 8'd3,  1'b0},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b1, 3'd5, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b1, 3'd4, 1'b0, 3'd0, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd2, 4'd8, 8'd5,  1'b0},
        '{2'd2, 2'd1, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b1, 3'd7, 2'd0, 4'd6, 8'd6,  1'b1},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b1, 3'd6, 1'b0, 3'd0, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd2, 4'd8, 8'd7,  1'b0},
        '{2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 4'd6, 8'd0,  1'b0},
        '{2'd2, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd0, 4'd4, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b1, 3'd1, 1'b1, 3'd2, 2'd0, 4'd4, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b1, 3'd0, 1'b1, 3'd3, 2'd0, 4'd4, 8'd0,  1'b0},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd2, 4'd6, 8'd9,  1'b0},
        '{2'd0, 2'd0, 1'b0, 3'd0, 1'b0, 3'd0, 2'd2, 4'd8, 8'd11, 1'b0}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        ren_cnt = '0; ren_kill = '0; ren_nspec = '0; ren_fault = '0;
        cmp_vld = '0; cmp_tag = '0; cmp_kill = '0; sq_req = 1'b0;
    endtask

    task automatic cmp1(input logic [2:0] t);
        cmp_vld = 2'b01; cmp_tag = {3'd0, t}; cmp_kill = '0;
    endtask

    task automatic cmp2(input logic [2:0] t0, input logic [2:0] t1);
        cmp_vld = 2'b11; cmp_tag = {t1, t0}; cmp_kill = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R12 reset state
        chk(bk_free == 4'd8, "R12 free", bk_free, 8);
        chk(!ren_stall, "R12 stall", ren_stall, 0);
        chk(alloc_seq == 8'd0 && alloc_tag == 3'd0, "R12 alloc", alloc_seq, 0);
        chk(bk_retired == 2'd0 && !bk_squash && !bk_robsq && !bk_nreq && !bk_fault,
            "R12 pulses", bk_retired, 0);
        rst_n = 1'b1;
        tick();

        // table: R1 R2 R4 R7 R8 R9
        for (int r = 0; r < 18; r++) begin
            idle_in();
            ren_cnt   = TBL[r].cnt;
            ren_nspec = TBL[r].nsp;
            cmp_vld   = {TBL[r].c1v, TBL[r].c0v};
            cmp_tag   = {TBL[r].c1t, TBL[r].c0t};
            tick();
            chk(bk_retired == TBL[r].xret, $sformatf("R1 R2 R8 retired row %0d", r),
                bk_retired, TBL[r].xret);
            chk(bk_free == TBL[r].xfree, $sformatf("R9 free row %0d", r),
                bk_free, TBL[r].xfree);
            chk(bk_nreq == TBL[r].xnreq, $sformatf("R4 nreq row %0d", r),
                bk_nreq, TBL[r].xnreq);
            if (TBL[r].xret != 0)
                chk(bk_seq == TBL[r].xseq, $sformatf("R1 seq row %0d", r), bk_seq, TBL[r].xseq);
            if (TBL[r].xnreq)
                chk(bk_nreq_seq == TBL[r].xseq, $sformatf("R4 nreq seq row %0d", r),
                    bk_nreq_seq, TBL[r].xseq);
        end

        // R3 killed head leaves without commit report: seq12 tag4, seq13 tag5
        idle_in(); ren_cnt = 2'd2; tick();
        idle_in(); cmp_vld = 2'b11; cmp_tag = {3'd5, 3'd4}; cmp_kill = 2'b01; tick();
        idle_in(); tick();
        chk(bk_retired == 2'd1, "R3 retired", bk_retired, 1);
        chk(bk_seq == 8'd13, "R3 seq", bk_seq, 13);
        chk(bk_free == 4'd8, "R3 free", bk_free, 8);

        // R7 killed rename slot skipped: slot1 becomes seq14 tag6
        idle_in(); ren_cnt = 2'd2; ren_kill = 2'b01; tick();
        chk(bk_free == 4'd7, "R7 free", bk_free, 7);
        chk(alloc_seq == 8'd15, "R7 alloc seq", alloc_seq, 15);
        chk(alloc_tag == 3'd7, "R7 alloc tag", alloc_tag, 7);
        idle_in(); cmp1(3'd6); tick();
        idle_in(); tick();
        chk(bk_retired == 2'd1 && bk_seq == 8'd14, "R7 retire", bk_seq, 14);

        // R11 fault pulse: seq15 tag7
        idle_in(); ren_cnt = 2'd1; ren_fault = 2'b01; tick();
        idle_in(); cmp1(3'd7); tick();
        idle_in(); tick();
        chk(bk_fault == 1'b1, "R11 fault", bk_fault, 1);
        chk(bk_seq == 8'd15, "R11 seq", bk_seq, 15);
        tick();
        chk(bk_fault == 1'b0, "R11 pulse end", bk_fault, 0);

        // fill: seq16..23 in tags 0..7
        for (int f = 0; f < 4; f++) begin
            idle_in(); ren_cnt = 2'd2; tick();
        end
        chk(bk_free == 4'd0, "R9 full", bk_free, 0);

        // R10 backpressure
        idle_in(); ren_cnt = 2'd1; #1;
        chk(ren_stall == 1'b1, "R10 stall", ren_stall, 1);
        tick();
        chk(bk_free == 4'd0 && alloc_seq == 8'd24, "R10 no insert", alloc_seq, 24);

        // R5 squash at seq20
        idle_in(); sq_req = 1'b1; sq_seq = 8'd20; sq_mispred = 1'b1; sq_taken = 1'b0;
        sq_npc = 16'hBEEF;
        tick();
        chk(bk_squash && bk_robsq, "R5 pulse", {bk_squash, bk_robsq}, 3);
        chk(bk_seq == 8'd20, "R5 seq", bk_seq, 20);
        chk(bk_npc == 16'hBEEF && bk_mispred && !bk_taken, "R5 pass", bk_npc, 16'hBEEF);

        // R6 walk, with completions during the walk (R8) and rename held off (R10)
        idle_in(); ren_cnt = 2'd1; cmp2(3'd0, 3'd1); #1;
        chk(ren_stall == 1'b1, "R10 stall in walk", ren_stall, 1);
        tick();
        chk(bk_robsq && !bk_squash && bk_seq == 8'd23, "R6 walk 1", bk_seq, 23);
        chk(bk_free == 4'd1, "R6 free 1", bk_free, 1);
        cmp2(3'd2, 3'd3); tick();
        chk(bk_robsq && bk_seq == 8'd22 && bk_free == 4'd2, "R6 walk 2", bk_seq, 22);
        cmp1(3'd4); tick();
        chk(bk_robsq && bk_seq == 8'd21 && bk_free == 4'd3, "R6 walk 3", bk_seq, 21);
        cmp_vld = '0; tick();
        chk(!bk_robsq && bk_retired == 2'd0, "R6 walk end", bk_robsq, 0);
        chk(bk_free == 4'd3 && alloc_seq == 8'd24, "R6 no insert", alloc_seq, 24);
        idle_in(); tick();
        chk(bk_retired == 2'd2 && bk_seq == 8'd17, "R8 marks during walk", bk_seq, 17);
        chk(bk_free == 4'd5, "R9 free after", bk_free, 5);
        idle_in(); ren_cnt = 2'd1; #1;
        chk(alloc_tag == 3'd5 && alloc_seq == 8'd24, "R7 tag after walk", alloc_tag, 5);
        tick();
        chk(bk_retired == 2'd2 && bk_seq == 8'd19, "R1 after walk", bk_seq, 19);
        chk(bk_free == 4'd6, "R9 free final", bk_free, 6);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule